// File: doc/BRIEF.md
# Carrier Burst Generator with Duty Control

This block produces a square carrier whose frequency and duty cycle come from one short prescaler chain. A 4-bit quarter-period divider drives a 2-bit phase counter. Together they act as a 6-bit prescaler: every carrier period is four quarters, and a duty code picks how many of those quarters are high. An 8-bit pulse counter counts carrier pulses on their falling edges and stops the carrier after a programmed number of pulses. Each start request therefore emits one burst of exactly that many pulses.

A data key input gates the carrier on its way to the pin, so a serial bit stream can key the burst. While the key is low the pin stays low, but the phase and the pulse count keep running. The key changes only what appears on the pin, not how long the burst lasts. The configuration is captured when a burst starts. A done flag reports that the burst has finished and stays set until the next start.

Top module: `carrier_burst_gen`

## Requirements
- R1: After reset, carrier_out is 0 and burst_done is 0.
- R2: With quarter divide value qdiv = z, each quarter-period lasts z+1 clock cycles, so one carrier period is 4*(z+1) cycles.
- R3: The duty code sets the number of high quarters at the start of each period: 2'b00 gives 1 (25%), 2'b01 gives 2 (50%), 2'b10 gives 3 (75%), and 2'b11 gives 2 (50%).
- R4: With burst_len = y, a burst contains y+1 pulses. The burst ends on the falling edge of the last pulse, and carrier_out then stays 0.
- R5: burst_done goes to 1 in the cycle the burst ends, stays 1 while idle, and goes back to 0 in the first cycle of the next burst.
- R6: While key is 0, carrier_out is 0 in the same cycle. The phase and pulse counting go on unchanged, so the burst end time does not depend on key.
- R7: A start received during a burst is ignored. Changes to qdiv, duty or burst_len during a burst have no effect until the next accepted start.
- R8: A start accepted at a clock edge makes carrier_out high, with key high, in the cycle that follows that edge. That cycle is the first cycle of a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| qdiv | input | 4 | Quarter-period divide value z; a quarter lasts z+1 clocks |
| duty | input | 2 | Duty code: 00 = 25%, 01 = 50%, 10 = 75%, 11 = 50% |
| burst_len | input | 8 | Burst length y; the burst has y+1 pulses |
| start | input | 1 | Request a burst; sampled on the clock edge while idle |
| key | input | 1 | Data key; 0 forces the pin low without pausing the count |
| carrier_out | output | 1 | Gated carrier |
| burst_done | output | 1 | Set when a burst ends, cleared when the next one starts |

## Verification
carrier_out and burst_done respond one clock edge after a start is captured. From then on they follow a closed-form schedule in the cycle count t since that edge. The output is high when t mod 4(z+1) is less than the high-quarter count times (z+1) and t is before the end time. The end time is y*4(z+1) plus the high-quarter count times (z+1), and done is set from the end time onward. Because key gates the output combinationally, its effect is due in the same cycle. The bench therefore changes key and start on the falling clock edge and compares 1 ns later, before the next rising edge. Every cycle of every burst, including a few idle cycles after it, is compared against the schedule computed in the bench. This covers randomized configurations, random keying, restarts attempted mid-burst and configuration changes during a burst.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
    localparam int QDIV_W = 4;
    localparam int PH_W   = 2;
    localparam int CNT_W  = 8;

    typedef enum logic [1:0] {
        DUTY_25 = 2'b00,
        DUTY_50 = 2'b01,
        DUTY_75 = 2'b10,
        DUTY_50B = 2'b11
    } duty_e;

    // Number of high quarters for a duty code
    function automatic logic [PH_W-1:0] high_quarters(input logic [1:0] code);
        case (duty_e'(code))
            DUTY_25: return PH_W'(1);
            DUTY_75: return PH_W'(3);
            default: return PH_W'(2);
        endcase
    endfunction

    typedef struct packed {
        logic              run;
        logic              done;
        logic [QDIV_W-1:0] lim;
        logic [PH_W-1:0]   hq;
        logic [CNT_W-1:0]  len;
    } ctl_t;
endpackage

// File: rtl/cbg_quarter_div.sv
module cbg_quarter_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] lim,
    output logic         tick,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == lim);
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = '0;
        else if (run)  cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/cbg_phase_gen.sv
module cbg_phase_gen #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] hq,
    output logic         hi,
    output logic         fall,
    output logic [W-1:0] qtr
);
    logic [W-1:0] qtr_d, qtr_q;

    always_comb begin
        hi    = (qtr_q < hq);
        fall  = tick && (qtr_q == hq - W'(1));
        qtr_d = qtr_q;
        if (clr)       qtr_d = '0;
        else if (tick) qtr_d = qtr_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qtr_q <= '0;
        else        qtr_q <= qtr_d;
    end

    assign qtr = qtr_q;
endmodule

// File: rtl/cbg_pulse_cnt.sv
module cbg_pulse_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         fall,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = fall && (cnt_q == len);
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (fall) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/carrier_burst_gen.sv
module carrier_burst_gen
    import cbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QDIV_W-1:0] qdiv,
    input  logic [1:0]        duty,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic              start,
    input  logic              key,
    output logic              carrier_out,
    output logic              burst_done
);
    ctl_t ctl_d, ctl_q;

    logic              go;
    logic              tick;
    logic              hi;
    logic              fall;
    logic              last;
    logic [QDIV_W-1:0] div_cnt;
    logic [PH_W-1:0]   qtr;

    cbg_quarter_div #(.W(QDIV_W)) u_qdiv (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (go),
        .run  (ctl_q.run),
        .lim  (ctl_q.lim),
        .tick (tick),
        .cnt  (div_cnt)
    );

    cbg_phase_gen #(.W(PH_W)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (go),
        .tick (tick),
        .hq   (ctl_q.hq),
        .hi   (hi),
        .fall (fall),
        .qtr  (qtr)
    );

    cbg_pulse_cnt #(.W(CNT_W)) u_pcnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (go),
        .fall (fall),
        .len  (ctl_q.len),
        .last (last)
    );

    always_comb begin
        go    = start && !ctl_q.run;
        ctl_d = ctl_q;
        if (go) begin
            ctl_d.run  = 1'b1;
            ctl_d.done = 1'b0;
            ctl_d.lim  = qdiv;
            ctl_d.hq   = high_quarters(duty);
            ctl_d.len  = burst_len;
        end else if (last) begin
            ctl_d.run  = 1'b0;
            ctl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{run: 1'b0, done: 1'b0, lim: '0, hq: PH_W'(2), len: '0};
        else        ctl_q <= ctl_d;
    end

    assign carrier_out = ctl_q.run && hi && key;
    assign burst_done  = ctl_q.done;
endmodule

// File: rtl/cbg_checker.sv
module cbg_checker
    import cbg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              key,
    input logic              carrier_out,
    input logic              burst_done,
    input logic              run_st,
    input logic [QDIV_W-1:0] div_cnt,
    input logic [QDIV_W-1:0] lim_st,
    input logic [PH_W-1:0]   qtr
);
    // R6: key low silences the pin
    a_r6_key_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !key |-> !carrier_out);

    // R3: the last quarter of a period is always low
    a_r3_last_quarter_low: assert property (@(posedge clk) disable iff (!rst_n)
        (qtr == 2'd3) |-> !carrier_out);

    // R2: divider wraps to zero after reaching its limit
    a_r2_quarter_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_st && div_cnt == lim_st) |=> (div_cnt == '0));

    // R4 / R5: a burst ends only by setting done
    a_r5_end_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_st) |-> burst_done);

    // R5: done and an active burst never coexist
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> !run_st);

    // R7: start during a burst leaves the captured limit alone
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (run_st && start) |=> $stable(lim_st));

    // R8: accepted start leads to an active burst in phase zero
    a_r8_start_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_st && start) |=> (run_st && qtr == '0 && div_cnt == '0));
endmodule

bind carrier_burst_gen cbg_checker i_cbg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .key        (key),
    .carrier_out(carrier_out),
    .burst_done (burst_done),
    .run_st     (ctl_q.run),
    .div_cnt    (div_cnt),
    .lim_st     (ctl_q.lim),
    .qtr        (qtr)
);

// File: tb/test_carrier_burst_gen.sv
`timescale 1ns/1ps
module test_carrier_burst_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] qdiv = '0;
    logic [1:0] duty = '0;
    logic [7:0] burst_len = '0;
    logic       start = 1'b0;
    logic       key = 1'b1;
    logic       carrier_out;
    logic       burst_done;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    carrier_burst_gen i_carrier_burst_gen (
        .clk(clk), .rst_n(rst_n), .qdiv(qdiv), .duty(duty),
        .burst_len(burst_len), .start(start), .key(key),
        .carrier_out(carrier_out), .burst_done(burst_done)
    );

    function automatic int hq_of(input int d);
        return (d == 0) ? 1 : (d == 2) ? 3 : 2;
    endfunction

    function automatic int end_of(input int z, input int d, input int y);
        return y * 4 * (z + 1) + hq_of(d) * (z + 1);
    endfunction

    function automatic bit exp_out(input int t, input int z, input int d, input int y, input bit k);
        return k && (t < end_of(z, d, y)) && ((t % (4 * (z + 1))) < hq_of(d) * (z + 1));
    endfunction

    task automatic cmp(input string req, input int t, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            if (n_bad < 20)
                $display("FAIL %s t=%0d actual=%b expected=%b", req, t, act, exp);
        end
    endtask

    // mode bit0: random key; bit1: mid-burst start; bit2: config churn
    task automatic burst(input int z, input int d, input int y, input int mode);
        int e = end_of(z, d, y);
        @(negedge clk);
        qdiv = 4'(z); duty = 2'(d); burst_len = 8'(y);
        start = 1'b1; key = 1'b1;
        for (int t = 0; t < e + 4; t++) begin
            @(negedge clk);
            start = 1'b0;
            key = mode[0] ? 1'($urandom_range(0, 1)) : 1'b1;
            if (mode[1] && t == 2 && e > 3) start = 1'b1;  // R7
            if (mode[2]) begin                             // R7
                qdiv = 4'($urandom); duty = 2'($urandom); burst_len = 8'($urandom);
            end
            #1;
            cmp((t == 0) ? "R8" : (key == 1'b0) ? "R6" : (t >= e) ? "R4" : "R2/R3",
                t, carrier_out, exp_out(t, z, d, y, key));
            cmp("R5", t, burst_done, (t >= e) ? 1'b1 : 1'b0);
        end
        start = 1'b0; key = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #3;
        cmp("R1", -1, carrier_out, 1'b0);
        cmp("R1", -1, burst_done, 1'b0);
        #10 rst_n = 1'b1;
        @(negedge clk);
        cmp("R1", -1, carrier_out, 1'b0);
        cmp("R1", -1, burst_done, 1'b0);
        // directed corners
        burst(0, 0, 0, 0);     // shortest
        burst(0, 3, 2, 0);     // R3 code 11 acts as 50%
        burst(2, 2, 3, 0);     // R3 75%
        burst(1, 1, 4, 2);     // R7 restart attempt
        burst(3, 0, 5, 1);     // R6 keyed
        burst(15, 1, 255, 0);  // R2 R4 max lengths
        burst(4, 2, 6, 4);     // R7 config churn
        // random mix
        for (int i = 0; i < 20; i++)
            burst($urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 24),
                  $urandom_range(0, 7));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule